// File: doc/BRIEF.md
# Serial EEPROM Configuration Auto-Loader

This block fills a bank of configuration registers from a serial EEPROM with a three-wire, chip-select-framed interface, and it does so by itself after reset. Once reset is released and a short settling delay has passed, it issues one read transaction per configuration word, walking upward from address 0. Each word is shifted serially into a holding register and then copied into its configuration register. When the last word arrives, the byte sum of everything read is compared with a fixed constant. On a mismatch, every loadable register falls back to its reset default in that same cycle.

While the load is running, the block tells the bus target logic to answer every I/O access with a retry. That answer is target-select and stop asserted, with target-ready held low. Configuration-space accesses are accepted normally the whole time. After the load finishes, a host-writable pin-control register can take over the serial pins for hand-driven transfers, and it also reads back the EEPROM's data line.

Top module: `sprom_autoload`

## Requirements
- R1: While reset is held, `load_done` and `csum_ok` are 0, `cfg_words` equals the `DEFAULTS` parameter, and `mw_cs` and `mw_sck` are 0.
- R2: With no other input, `mw_cs` first rises on the (START_DLY+1)-th rising clock edge after reset is released.
- R3: Each read holds `mw_cs` high and sends 9 bits on `mw_mosi`, most significant first: 1, 1, 0, then the 6-bit word address. The output bit changes on the falling `mw_sck` edge. `mw_cs` drops between reads, and the addresses run 0, 1, …, N_WORDS-1 in order.
- R4: The `mw_sck` period is 2*CLK_DIV system clock cycles.
- R5: The 16 data bits that follow the address are sampled on rising `mw_sck` edges, MSB first. The word read from address i lands in `cfg_words[16*i +: 16]`.
- R6: While `load_done` is 0, `io_access` gives `tgt_devsel`=1, `tgt_stop`=1, `tgt_trdy`=0. `cfg_access` always gives `tgt_devsel`=1, `tgt_trdy`=1, `tgt_stop`=0. After `load_done`, `io_access` gives `tgt_devsel`=1, `tgt_trdy`=1, `tgt_stop`=0.
- R7: If the sum modulo 256 of all bytes of all loaded words equals CSUM_TARGET, then `load_done` and `csum_ok` rise together and the registers keep the loaded words.
- R8: On a checksum mismatch, `load_done` rises with `csum_ok`=0, and every register of `cfg_words` returns to `DEFAULTS` on that same edge.
- R9: `load_done` stays high until the next reset. After it rises, the block starts no further serial transfer.
- R10: After `load_done`, a `dir_wr` pulse stores `dir_wdata`. The bits are: bit 3 enable, bit 2 data-out, bit 1 clock, bit 0 chip select. With enable set, these bits drive `mw_mosi`, `mw_sck` and `mw_cs`; with enable clear, all three are 0. `dir_rdata` is `{mw_miso, stored bits[3:0]}`.
- R11: A `dir_wr` pulse while `load_done` is 0 is ignored, so `dir_rdata[3:0]` still reads 0 after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_access | input | 1 | Bus target is decoding an I/O access |
| cfg_access | input | 1 | Bus target is decoding a configuration access (exclusive with io_access) |
| tgt_devsel | output | 1 | Claim the access |
| tgt_stop | output | 1 | Request termination (retry when tgt_trdy is low) |
| tgt_trdy | output | 1 | Target ready for data |
| dir_wr | input | 1 | Write strobe for the pin-control register |
| dir_wdata | input | 4 | Pin-control write data |
| dir_rdata | output | 5 | Pin-control readback with serial data-in in bit 4 |
| mw_cs | output | 1 | EEPROM chip select |
| mw_sck | output | 1 | EEPROM serial clock |
| mw_mosi | output | 1 | Serial data to the EEPROM |
| mw_miso | input | 1 | Serial data from the EEPROM |
| cfg_words | output | N_WORDS*DATA_W | Configuration register bank, word i at bits 16*i |
| load_done | output | 1 | Automatic load has finished |
| csum_ok | output | 1 | Checksum of the load matched |

## Verification
On every cycle the assertions check four things. I/O accesses get the retry answer while the loader state is short of finished. The done flag never falls. The pin-control register stays clear before the load ends, and no chip select comes from the engine afterwards. Each frame opens with a 1 and keeps its clock low whenever chip select is low. Only the bench scenarios can show the rest: the exact start delay, the serial clock period, the command bits and address order, the assembly of data words, and that the byte-sum decision keeps or rolls back the whole bank. Both the passing and the failing data set are run.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
   localparam int          RD_OP_W = 3;
   localparam logic [2:0]  RD_OP   = 3'b110;   // start bit, then read opcode
   localparam int          PIN_CS  = 0;
   localparam int          PIN_SK  = 1;
   localparam int          PIN_DO  = 2;
   localparam int          PIN_EN  = 3;

   typedef enum logic [1:0] {LD_WAIT, LD_ISSUE, LD_BUSY, LD_DONE} ld_state_t;
   typedef enum logic [1:0] {SH_IDLE, SH_XFER, SH_GAP}            sh_state_t;
endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CLK_DIV < 1) begin : g_bad
         $error("CLK_DIV must be at least 1");
      end else if (CLK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(CLK_DIV);
         localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/mw_read_engine.sv
module mw_read_engine
   import sprom_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic              miso,
   output logic              cs,
   output logic              sk,
   output logic              sdo,
   output logic [DATA_W-1:0] word,
   output logic              word_vld,
   output logic              idle
);
   localparam int CMD_BITS = RD_OP_W + ADDR_W;
   localparam int TOTAL    = CMD_BITS + DATA_W;
   localparam int CNT_W    = $clog2(TOTAL + 1);
   localparam logic [CNT_W-1:0] CMD_C = CNT_W'(CMD_BITS);
   localparam logic [CNT_W-1:0] TOT_C = CNT_W'(TOTAL);

   sh_state_t            st;
   logic [CNT_W-1:0]     cnt;
   logic [CMD_BITS-1:0]  cmd_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SH_IDLE;
         cs       <= 1'b0;
         sk       <= 1'b0;
         sdo      <= 1'b0;
         cnt      <= '0;
         cmd_sr   <= '0;
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= 1'b0;
         case (st)
            SH_IDLE: if (start) begin
               st     <= SH_XFER;
               cs     <= 1'b1;
               sk     <= 1'b0;
               cnt    <= '0;
               cmd_sr <= {RD_OP, addr};
               sdo    <= RD_OP[RD_OP_W-1];
            end
            SH_XFER: if (tick) begin
               if (!sk) begin
                  sk  <= 1'b1;
                  cnt <= cnt + 1'b1;
                  if (cnt >= CMD_C) word <= {word[DATA_W-2:0], miso};
               end else begin
                  sk <= 1'b0;
                  if (cnt == TOT_C) begin
                     cs  <= 1'b0;
                     sdo <= 1'b0;
                     st  <= SH_GAP;
                  end else begin
                     cmd_sr <= {cmd_sr[CMD_BITS-2:0], 1'b0};
                     sdo    <= cmd_sr[CMD_BITS-2];
                  end
               end
            end
            SH_GAP: if (tick) begin
               st       <= SH_IDLE;
               word_vld <= 1'b1;
            end
            default: st <= SH_IDLE;
         endcase
      end
   end

   assign idle = (st == SH_IDLE);

   a_r3_frame_opens_with_one: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs) |-> sdo)
      else $error("frame did not begin with a start bit of 1");

   a_r3_clock_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !sk)
      else $error("serial clock high with chip select low");
endmodule

// File: rtl/csum_acc.sv
module csum_acc #(
   parameter int DATA_W = 16,
   parameter int SUM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              add,
   input  logic [DATA_W-1:0] word,
   output logic [SUM_W-1:0]  sum_next
);
   localparam int NB = DATA_W / 8;
   logic [SUM_W-1:0] sum_q;

   always_comb begin
      sum_next = sum_q;
      if (add)
         for (int b = 0; b < NB; b++)
            sum_next = sum_next + SUM_W'(word[8*b +: 8]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= sum_next;
   end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
   parameter int N_WORDS = 4,
   parameter int DATA_W  = 16,
   parameter logic [N_WORDS*DATA_W-1:0] DEFAULTS = '0,
   localparam int IW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IW-1:0]               wr_idx,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic                        restore,
   output logic [N_WORDS*DATA_W-1:0]   cfg
);
   for (genvar g = 0; g < N_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg[g*DATA_W +: DATA_W] <= DEFAULTS[g*DATA_W +: DATA_W];
         else if (restore)
            cfg[g*DATA_W +: DATA_W] <= DEFAULTS[g*DATA_W +: DATA_W];
         else if (wr_en && wr_idx == IW'(g))
            cfg[g*DATA_W +: DATA_W] <= wr_data;
      end
   end
endmodule

// File: rtl/sprom_autoload.sv
module sprom_autoload
   import sprom_pkg::*;
#(
   parameter int N_WORDS   = 4,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter int CLK_DIV   = 2,
   parameter int START_DLY = 8,
   parameter logic [7:0] CSUM_TARGET = 8'hFF,
   parameter logic [N_WORDS*DATA_W-1:0] DEFAULTS = {16'hD003, 16'hC002, 16'hB001, 16'hA000}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       io_access,
   input  logic                       cfg_access,
   output logic                       tgt_devsel,
   output logic                       tgt_stop,
   output logic                       tgt_trdy,
   input  logic                       dir_wr,
   input  logic [3:0]                 dir_wdata,
   output logic [4:0]                 dir_rdata,
   output logic                       mw_cs,
   output logic                       mw_sck,
   output logic                       mw_mosi,
   input  logic                       mw_miso,
   output logic [N_WORDS*DATA_W-1:0]  cfg_words,
   output logic                       load_done,
   output logic                       csum_ok
);
   localparam int IW  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
   localparam int DW  = $clog2(START_DLY + 1);
   localparam logic [IW-1:0] LAST_IDX = IW'(N_WORDS - 1);
   localparam logic [DW-1:0] DLY_END  = DW'(START_DLY - 1);

   if (DATA_W != 16)          begin : g_chk_w  $error("data word must be 16 bits"); end
   if (N_WORDS > 2**ADDR_W)   begin : g_chk_n  $error("more words than addresses"); end
   if (START_DLY < 1)         begin : g_chk_d  $error("START_DLY must be at least 1"); end

   ld_state_t          st;
   logic [DW-1:0]      dly_cnt;
   logic [IW-1:0]      widx;
   logic               tick, eng_start, eng_cs, eng_sk, eng_sdo, word_vld, eng_idle;
   logic [DATA_W-1:0]  word;
   logic [7:0]         sum_next;
   logic               last_word, restore;
   logic [3:0]         dir_q;

   mw_tick #(.CLK_DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

   mw_read_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(eng_start),
      .addr(ADDR_W'(widx)), .miso(mw_miso),
      .cs(eng_cs), .sk(eng_sk), .sdo(eng_sdo),
      .word(word), .word_vld(word_vld), .idle(eng_idle));

   csum_acc #(.DATA_W(DATA_W), .SUM_W(8)) u_sum (
      .clk(clk), .rst_n(rst_n), .add(word_vld), .word(word), .sum_next(sum_next));

   assign last_word = word_vld && (widx == LAST_IDX);
   assign restore   = last_word && (sum_next != CSUM_TARGET);
   assign eng_start = (st == LD_ISSUE) && eng_idle;

   cfg_bank #(.N_WORDS(N_WORDS), .DATA_W(DATA_W), .DEFAULTS(DEFAULTS)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(word_vld), .wr_idx(widx),
      .wr_data(word), .restore(restore), .cfg(cfg_words));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= LD_WAIT;
         dly_cnt   <= '0;
         widx      <= '0;
         load_done <= 1'b0;
         csum_ok   <= 1'b0;
      end else begin
         case (st)
            LD_WAIT:
               if (dly_cnt == DLY_END) st <= LD_ISSUE;
               else                    dly_cnt <= dly_cnt + 1'b1;
            LD_ISSUE:
               if (eng_idle) st <= LD_BUSY;
            LD_BUSY:
               if (last_word) begin
                  st        <= LD_DONE;
                  load_done <= 1'b1;
                  csum_ok   <= (sum_next == CSUM_TARGET);
               end else if (word_vld) begin
                  widx <= widx + 1'b1;
                  st   <= LD_ISSUE;
               end
            default: st <= LD_DONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     dir_q <= '0;
      else if (dir_wr && load_done)   dir_q <= dir_wdata;
   end

   always_comb begin
      if (!load_done) begin
         mw_cs   = eng_cs;
         mw_sck  = eng_sk;
         mw_mosi = eng_sdo;
      end else begin
         mw_cs   = dir_q[PIN_EN] & dir_q[PIN_CS];
         mw_sck  = dir_q[PIN_EN] & dir_q[PIN_SK];
         mw_mosi = dir_q[PIN_EN] & dir_q[PIN_DO];
      end
   end

   assign dir_rdata  = {mw_miso, dir_q};
   assign tgt_devsel = io_access | cfg_access;
   assign tgt_stop   = io_access & ~load_done;
   assign tgt_trdy   = cfg_access | (io_access & load_done);

   a_r6_io_retried_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
      (io_access && st != LD_DONE) |-> (tgt_devsel && tgt_stop && !tgt_trdy))
      else $error("I/O access not retried during load");

   a_r9_done_is_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done)
      else $error("done flag fell");

   a_r9_engine_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LD_DONE) |-> !eng_cs)
      else $error("serial transfer after load finished");

   a_r11_pins_locked_early: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |-> (dir_q == 4'd0))
      else $error("pin-control register written during load");

   a_r7_ok_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
      csum_ok |-> load_done)
      else $error("checksum flag without done");
endmodule

// File: tb/sprom_autoload_tb.sv
module sprom_autoload_tb;
   localparam int N_WORDS   = 4;
   localparam int CLK_DIV   = 2;
   localparam int START_DLY = 8;
   localparam logic [63:0] DEF = 64'h7700_6600_5500_4400;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 4 time-unit period: 250 MHz at 1 ns units

   logic rst_n = 1'b0, io_access = 1'b0, cfg_access = 1'b0, dir_wr = 1'b0;
   logic [3:0] dir_wdata = '0;
   logic [4:0] dir_rdata;
   logic tgt_devsel, tgt_stop, tgt_trdy, mw_cs, mw_sck, mw_mosi, mw_miso;
   logic [63:0] cfg_words;
   logic load_done, csum_ok;

   sprom_autoload #(.N_WORDS(N_WORDS), .CLK_DIV(CLK_DIV), .START_DLY(START_DLY),
                    .CSUM_TARGET(8'hFF), .DEFAULTS(DEF)) u_dut (
      .clk(clk), .rst_n(rst_n), .io_access(io_access), .cfg_access(cfg_access),
      .tgt_devsel(tgt_devsel), .tgt_stop(tgt_stop), .tgt_trdy(tgt_trdy),
      .dir_wr(dir_wr), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
      .mw_cs(mw_cs), .mw_sck(mw_sck), .mw_mosi(mw_mosi), .mw_miso(mw_miso),
      .cfg_words(cfg_words), .load_done(load_done), .csum_ok(csum_ok));

   int n_chk = 0, n_err = 0, cyc = 0;
   logic [8:0]  cmd_q[$];
   logic [63:0] cfg_q[$];
   bit          ok_q[$];
   logic [15:0] mem [0:63];

   task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!cond) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) cyc++;

   // EEPROM behavioural model: commands counted on rising clock, data driven on falling clock
   int rx_cnt = 0, last_cyc = 0;
   bit per_done = 0;
   logic [8:0] rx_sr = '0;
   logic mdl_drive = 1'b0, mdl_bit = 1'b0, idle_miso = 1'b0;
   assign mw_miso = mdl_drive ? mdl_bit : idle_miso;

   always @(posedge mw_sck or negedge mw_cs) begin
      if (!mw_cs) rx_cnt = 0;
      else begin
         if (rx_cnt >= 1 && !per_done) begin
            chk((cyc - last_cyc) == 2*CLK_DIV, "R4 sck period", 64'(cyc - last_cyc), 64'(2*CLK_DIV));
            per_done = 1;
         end
         last_cyc = cyc;
         if (rx_cnt < 9) rx_sr = {rx_sr[7:0], mw_mosi};
         rx_cnt++;
         if (rx_cnt == 9) begin
            if (cmd_q.size() == 0) chk(0, "R3 unexpected command", 64'(rx_sr), 0);
            else begin
               logic [8:0] e;
               e = cmd_q.pop_front();
               chk(rx_sr == e, "R3 command bits and address", 64'(rx_sr), 64'(e));
            end
         end
      end
   end

   always @(negedge mw_sck) begin
      if (mw_cs && rx_cnt >= 9 && rx_cnt < 25) begin
         mdl_bit   = mem[rx_sr[5:0]][24 - rx_cnt];
         mdl_drive = 1'b1;
      end else mdl_drive = 1'b0;
   end

   // result monitor: compares the bank when the load completes
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (load_done && !prev_done) begin
         if (cfg_q.size() == 0) chk(0, "R5 unexpected completion", cfg_words, 0);
         else begin
            logic [63:0] e;
            bit          eo;
            e  = cfg_q.pop_front();
            eo = ok_q.pop_front();
            if (eo) begin
               chk(cfg_words == e, "R5 loaded words in bank", cfg_words, e);
               chk(csum_ok == 1'b1, "R7 checksum pass flag", 64'(csum_ok), 1);
            end else begin
               chk(cfg_words == e, "R8 rollback to defaults", cfg_words, e);
               chk(csum_ok == 1'b0, "R8 checksum fail flag", 64'(csum_ok), 0);
            end
         end
      end
      prev_done = load_done;
   end

   always @(negedge clk) begin
      if (cyc > 50000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d expected<=50000", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic run_load(input bit bad);
      logic [7:0]  s;
      logic [63:0] exp;
      int          n;
      bit          quiet;
      mem[0] = 16'h1234; mem[1] = 16'hABCD; mem[2] = 16'h0F0F;
      s = 8'h00;
      for (int i = 0; i < 3; i++) begin
         s = s + mem[i][15:8];
         s = s + mem[i][7:0];
      end
      mem[3] = {8'h00, 8'hFF - s};
      if (bad) mem[3] = mem[3] + 16'h0001;
      for (int i = 0; i < N_WORDS; i++) cmd_q.push_back({3'b110, 6'(i)});
      exp = bad ? DEF : {mem[3], mem[2], mem[1], mem[0]};
      cfg_q.push_back(exp);
      ok_q.push_back(!bad);
      per_done = 0;

      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(load_done == 0 && csum_ok == 0, "R1 flags in reset", {load_done, csum_ok}, 0);
      chk(cfg_words == DEF, "R1 bank defaults in reset", cfg_words, DEF);
      chk(mw_cs == 0 && mw_sck == 0, "R1 pins idle in reset", {mw_cs, mw_sck}, 0);

      rst_n = 1'b1;
      n = 0;
      while (!mw_cs && n < 100) begin @(negedge clk); n++; end
      chk(n == START_DLY + 1, "R2 start delay", 64'(n), 64'(START_DLY + 1));

      io_access = 1'b1; #1;
      chk(tgt_devsel && tgt_stop && !tgt_trdy, "R6 io retried while loading",
          {tgt_devsel, tgt_stop, tgt_trdy}, 3'b110);
      io_access = 1'b0; cfg_access = 1'b1; #1;
      chk(tgt_devsel && !tgt_stop && tgt_trdy, "R6 config accepted while loading",
          {tgt_devsel, tgt_stop, tgt_trdy}, 3'b101);
      cfg_access = 1'b0;
      dir_wr = 1'b1; dir_wdata = 4'hF;
      @(negedge clk); dir_wr = 1'b0; dir_wdata = 4'h0;

      n = 0;
      while (!load_done && n < 5000) begin @(negedge clk); n++; end
      chk(load_done == 1, "R9 load completes", 64'(load_done), 1);
      chk(dir_rdata[3:0] == 4'h0, "R11 early pin write ignored", 64'(dir_rdata[3:0]), 0);
      io_access = 1'b1; #1;
      chk(tgt_devsel && !tgt_stop && tgt_trdy, "R6 io accepted after load",
          {tgt_devsel, tgt_stop, tgt_trdy}, 3'b101);
      io_access = 1'b0;
      quiet = 1;
      repeat (100) begin
         @(negedge clk);
         if (mw_cs || mw_sck || !load_done) quiet = 0;
      end
      chk(quiet, "R9 no transfer after done", 64'(quiet), 1);
      chk(cmd_q.size() == 0, "R3 every address read", 64'(cmd_q.size()), 0);
   endtask

   task automatic pin_write(input logic [3:0] v);
      dir_wr = 1'b1; dir_wdata = v;
      @(negedge clk);
      dir_wr = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
      run_load(1'b0);

      pin_write(4'b1101);
      chk({mw_cs, mw_sck, mw_mosi} == 3'b101, "R10 pins follow register",
          {mw_cs, mw_sck, mw_mosi}, 3'b101);
      idle_miso = 1'b1; #1;
      chk(dir_rdata == 5'b11101, "R10 readback with data-in", 64'(dir_rdata), 5'b11101);
      pin_write(4'b1010);
      chk({mw_cs, mw_sck, mw_mosi} == 3'b010, "R10 clock pin alone",
          {mw_cs, mw_sck, mw_mosi}, 3'b010);
      pin_write(4'b0111);
      chk({mw_cs, mw_sck, mw_mosi} == 3'b000, "R10 enable clear parks pins",
          {mw_cs, mw_sck, mw_mosi}, 3'b000);
      idle_miso = 1'b0; #1;
      chk(dir_rdata == 5'b00111, "R10 readback without data-in", 64'(dir_rdata), 5'b00111);

      run_load(1'b1);

      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule